// File: doc/BRIEF.md
# Block-Move DMA Engine with Selectable Bus Sharing

This block copies a contiguous run of words between one peripheral and main memory without the processor's help. The processor programs a first memory address, a word count, a peripheral select and a control word through a small register-write port. It then issues a start command. After that the engine moves every word alone and signals completion through a level interrupt. Each word passes through an internal buffer register. In device-to-memory transfers the word is taken from the device and then written to memory. In memory-to-device transfers it is read from memory and then handed to the device. The memory address steps up by one for each word.

The memory bus is shared with the processor in one of three ways, chosen in the control word. In halt mode the engine stops the processor and keeps the bus for the whole block. In cycle-stealing mode it asks for the bus only for the single memory beat of each word and gives it back between words. In alternate-slot mode it needs no arbitration and uses only the DMA half of each processor work cycle, which the system marks with an external phase signal. Memory and device are simple valid/ready ports. Memory read data is returned in the same cycle as the accepted request.

Top module: `bmv_top`

## Requirements
- R1: While reset is applied and after it is released, `irq`, `busy`, `bus_req`, `cpu_stop`, `mem_valid`, `dev_rx_ready` and `dev_tx_valid` are low.
- R2: With control bit 0 clear (device to memory), word i received from the device is written to memory address base+i, for i = 0 .. count-1. The words at base-1 and base+count are left unchanged.
- R3: With control bit 0 set (memory to device), the words at base .. base+count-1 are read in ascending order and delivered to the device in that order. `dev_sel` carries the programmed peripheral select.
- R4: Exactly `count` memory beats occur per transfer. At the end `busy` falls and `irq` rises. `irq` then stays high until a command write with bit 1 set. While idle, no memory or device handshake signal is asserted.
- R5: A start with a programmed count of zero performs no memory access, leaves `busy` low and raises `irq` at the clock edge that takes the command.
- R6: A start command (command write with bit 0 set) issued while busy is ignored. The running transfer completes with its original count. Writes to the setup registers during a transfer affect only later transfers.
- R7: Halt mode (control bits 2:1 = 00, and the unused code 11 behaves the same): `bus_req` and `cpu_stop` stay high for the whole transfer. No memory request is made while `bus_grant` is low.
- R8: Cycle-stealing mode (bits 2:1 = 01): `bus_req` is high only while a memory beat is pending and drops between words, with no device handshake while it is held. Memory requests are made only with `bus_grant` high, and `cpu_stop` stays low.
- R9: Alternate-slot mode (bits 2:1 = 10): `bus_req` and `cpu_stop` stay low. Memory requests are made only while `slot_phase` is high.
- R10: Register selects are: 0 first address, 1 word count, 2 peripheral select, 3 control, 4 command. Setup values are latched at start, so a transfer uses the values that were programmed before it began.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | AW | Register write data |
| irq | output | 1 | Completion interrupt, level |
| busy | output | 1 | Transfer in progress |
| bus_req | output | 1 | Memory bus request |
| bus_grant | input | 1 | Memory bus grant |
| cpu_stop | output | 1 | Processor stop request (halt mode) |
| slot_phase | input | 1 | High during the DMA half of a work cycle |
| mem_valid | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid with mem_ready |
| mem_ready | input | 1 | Memory accepts the request |
| dev_sel | output | DEVW | Selected peripheral |
| dev_rx_valid | input | 1 | Device offers a word |
| dev_rx_data | input | DW | Word from the device |
| dev_rx_ready | output | 1 | Engine takes a device word |
| dev_tx_valid | output | 1 | Engine offers a word to the device |
| dev_tx_data | output | DW | Word to the device |
| dev_tx_ready | input | 1 | Device takes the word |

## Verification
The hardest state to reach from the ports is a transfer that has started but cannot touch memory because the grant is withheld. A second start and new setup values must arrive during that stall. The bench gets there by holding `bus_grant` low after a halt-mode start. It confirms that no memory request appears, rewrites the count and issues a second start, then releases the grant and counts the beats. Every transfer also runs with a toggling slot phase, stalls on both device sides and memory wait states. A per-cycle monitor checks that each memory beat falls inside its mode's permission.

// File: rtl/bmv_pkg.sv
package bmv_pkg;

  typedef enum logic [1:0] {
    SHARE_HALT  = 2'd0,
    SHARE_STEAL = 2'd1,
    SHARE_SLOT  = 2'd2,
    SHARE_RSVD  = 2'd3
  } share_e;

  typedef enum logic [2:0] {
    RS_ADDR  = 3'd0,
    RS_COUNT = 3'd1,
    RS_DEV   = 3'd2,
    RS_CTRL  = 3'd3,
    RS_CMD   = 3'd4
  } regsel_e;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_DEV_IN  = 3'd1,
    ST_MEM_WR  = 3'd2,
    ST_MEM_RD  = 3'd3,
    ST_DEV_OUT = 3'd4
  } eng_st_e;

  localparam int CTRL_DIR_BIT   = 0;
  localparam int CTRL_MODE_LSB  = 1;
  localparam int CMD_START_BIT  = 0;
  localparam int CMD_CLEAR_BIT  = 1;

endpackage

// File: rtl/bmv_regs.sv
module bmv_regs
  import bmv_pkg::*;
#(
  parameter int AW   = 16,
  parameter int DEVW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [2:0]      cfg_sel,
  input  logic [AW-1:0]   cfg_wdata,
  input  logic            busy_i,
  input  logic            done_i,
  output logic [AW-1:0]   base_o,
  output logic [AW-1:0]   cnt_o,
  output logic [DEVW-1:0] dev_o,
  output logic            dir_o,
  output share_e          mode_o,
  output logic            start_o,
  output logic            irq_o
);

  logic [AW-1:0]   base_q, cnt_q;
  logic [DEVW-1:0] dev_q;
  logic            dir_q, irq_q, irq_d;
  share_e          mode_q;

  logic en_addr, en_cnt, en_dev, en_ctrl, is_cmd, clr_req;

  always_comb begin
    en_addr = cfg_we && (cfg_sel == RS_ADDR);
    en_cnt  = cfg_we && (cfg_sel == RS_COUNT);
    en_dev  = cfg_we && (cfg_sel == RS_DEV);
    en_ctrl = cfg_we && (cfg_sel == RS_CTRL);
    is_cmd  = cfg_we && (cfg_sel == RS_CMD);
    start_o = is_cmd && cfg_wdata[CMD_START_BIT] && !busy_i;
    clr_req = is_cmd && cfg_wdata[CMD_CLEAR_BIT];
    // completion wins over a clear in the same cycle
    irq_d   = done_i ? 1'b1 : (clr_req ? 1'b0 : irq_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
      dev_q  <= '0;
      dir_q  <= 1'b0;
      mode_q <= SHARE_HALT;
      irq_q  <= 1'b0;
    end else begin
      if (en_addr) base_q <= cfg_wdata;
      if (en_cnt)  cnt_q  <= cfg_wdata;
      if (en_dev)  dev_q  <= cfg_wdata[DEVW-1:0];
      if (en_ctrl) begin
        dir_q  <= cfg_wdata[CTRL_DIR_BIT];
        mode_q <= share_e'(cfg_wdata[CTRL_MODE_LSB +: 2]);
      end
      irq_q <= irq_d;
    end
  end

  assign base_o = base_q;
  assign cnt_o  = cnt_q;
  assign dev_o  = dev_q;
  assign dir_o  = dir_q;
  assign mode_o = mode_q;
  assign irq_o  = irq_q;

endmodule

// File: rtl/bmv_share.sv
module bmv_share
  import bmv_pkg::*;
(
  input  share_e mode_i,
  input  logic   busy_i,
  input  logic   mem_phase_i,
  input  logic   bus_grant_i,
  input  logic   slot_phase_i,
  output logic   bus_req_o,
  output logic   cpu_stop_o,
  output logic   mem_ok_o
);

  always_comb begin
    bus_req_o  = 1'b0;
    cpu_stop_o = 1'b0;
    mem_ok_o   = 1'b0;
    unique case (mode_i)
      SHARE_STEAL: begin
        bus_req_o = mem_phase_i;
        mem_ok_o  = bus_grant_i;
      end
      SHARE_SLOT: begin
        mem_ok_o  = slot_phase_i;
      end
      default: begin
        bus_req_o  = busy_i;
        cpu_stop_o = busy_i;
        mem_ok_o   = bus_grant_i;
      end
    endcase
  end

endmodule

// File: rtl/bmv_engine.sv
module bmv_engine
  import bmv_pkg::*;
#(
  parameter int AW   = 16,
  parameter int DW   = 16,
  parameter int DEVW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [AW-1:0]   base_i,
  input  logic [AW-1:0]   cnt_i,
  input  logic [DEVW-1:0] dev_i,
  input  logic            dir_i,
  input  share_e          mode_i,
  input  logic            mem_ok_i,
  input  logic            mem_ready_i,
  input  logic [DW-1:0]   mem_rdata_i,
  input  logic            dev_rx_valid_i,
  input  logic [DW-1:0]   dev_rx_data_i,
  input  logic            dev_tx_ready_i,
  output logic            busy_o,
  output logic            mem_phase_o,
  output logic            done_o,
  output share_e          mode_run_o,
  output logic            mem_valid_o,
  output logic            mem_we_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [DW-1:0]   mem_wdata_o,
  output logic [DEVW-1:0] dev_sel_o,
  output logic            dev_rx_ready_o,
  output logic            dev_tx_valid_o,
  output logic [DW-1:0]   dev_tx_data_o
);

  localparam logic [AW-1:0] ONE = AW'(1);

  eng_st_e         st_q, st_d;
  logic [AW-1:0]   addr_q, addr_d, left_q, left_d;
  logic [DW-1:0]   buf_q, buf_d;
  share_e          mode_q, mode_d;
  logic [DEVW-1:0] dev_q, dev_d;
  logic            mem_hs;

  always_comb begin
    st_d   = st_q;
    addr_d = addr_q;
    left_d = left_q;
    buf_d  = buf_q;
    mode_d = mode_q;
    dev_d  = dev_q;
    done_o = 1'b0;
    mem_valid_o    = 1'b0;
    mem_we_o       = 1'b0;
    dev_rx_ready_o = 1'b0;
    dev_tx_valid_o = 1'b0;
    mem_hs = mem_ok_i && mem_ready_i;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          if (cnt_i == '0) begin
            done_o = 1'b1;
          end else begin
            st_d   = dir_i ? ST_MEM_RD : ST_DEV_IN;
            addr_d = base_i;
            left_d = cnt_i;
            dev_d  = dev_i;
            mode_d = (mode_i == SHARE_RSVD) ? SHARE_HALT : mode_i;
          end
        end
      end
      ST_DEV_IN: begin
        dev_rx_ready_o = 1'b1;
        if (dev_rx_valid_i) begin
          buf_d = dev_rx_data_i;
          st_d  = ST_MEM_WR;
        end
      end
      ST_MEM_WR: begin
        mem_valid_o = mem_ok_i;
        mem_we_o    = 1'b1;
        if (mem_hs) begin
          addr_d = addr_q + ONE;
          left_d = left_q - ONE;
          if (left_q == ONE) begin
            st_d   = ST_IDLE;
            done_o = 1'b1;
          end else begin
            st_d = ST_DEV_IN;
          end
        end
      end
      ST_MEM_RD: begin
        mem_valid_o = mem_ok_i;
        if (mem_hs) begin
          buf_d  = mem_rdata_i;
          addr_d = addr_q + ONE;
          st_d   = ST_DEV_OUT;
        end
      end
      ST_DEV_OUT: begin
        dev_tx_valid_o = 1'b1;
        if (dev_tx_ready_i) begin
          left_d = left_q - ONE;
          if (left_q == ONE) begin
            st_d   = ST_IDLE;
            done_o = 1'b1;
          end else begin
            st_d = ST_MEM_RD;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      left_q <= '0;
      buf_q  <= '0;
      mode_q <= SHARE_HALT;
      dev_q  <= '0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
      left_q <= left_d;
      buf_q  <= buf_d;
      mode_q <= mode_d;
      dev_q  <= dev_d;
    end
  end

  assign busy_o        = (st_q != ST_IDLE);
  assign mem_phase_o   = (st_q == ST_MEM_WR) || (st_q == ST_MEM_RD);
  assign mode_run_o    = mode_q;
  assign mem_addr_o    = addr_q;
  assign mem_wdata_o   = buf_q;
  assign dev_tx_data_o = buf_q;
  assign dev_sel_o     = dev_q;

endmodule

// File: rtl/bmv_top.sv
module bmv_top
  import bmv_pkg::*;
#(
  parameter int AW   = 16,
  parameter int DW   = 16,
  parameter int DEVW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [2:0]      cfg_sel,
  input  logic [AW-1:0]   cfg_wdata,
  output logic            irq,
  output logic            busy,
  output logic            bus_req,
  input  logic            bus_grant,
  output logic            cpu_stop,
  input  logic            slot_phase,
  output logic            mem_valid,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            mem_ready,
  output logic [DEVW-1:0] dev_sel,
  input  logic            dev_rx_valid,
  input  logic [DW-1:0]   dev_rx_data,
  output logic            dev_rx_ready,
  output logic            dev_tx_valid,
  output logic [DW-1:0]   dev_tx_data,
  input  logic            dev_tx_ready
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign core_rst_n = rsync_q[1];

  logic [AW-1:0]   base_w, cnt_w;
  logic [DEVW-1:0] dev_w;
  logic            dir_w, start_w, done_w, mem_phase_w, mem_ok_w;
  share_e          mode_cfg_w, run_mode;

  bmv_regs #(.AW(AW), .DEVW(DEVW)) u_regs (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .cfg_we   (cfg_we),
    .cfg_sel  (cfg_sel),
    .cfg_wdata(cfg_wdata),
    .busy_i   (busy),
    .done_i   (done_w),
    .base_o   (base_w),
    .cnt_o    (cnt_w),
    .dev_o    (dev_w),
    .dir_o    (dir_w),
    .mode_o   (mode_cfg_w),
    .start_o  (start_w),
    .irq_o    (irq)
  );

  bmv_engine #(.AW(AW), .DW(DW), .DEVW(DEVW)) u_eng (
    .clk           (clk),
    .rst_n         (core_rst_n),
    .start_i       (start_w),
    .base_i        (base_w),
    .cnt_i         (cnt_w),
    .dev_i         (dev_w),
    .dir_i         (dir_w),
    .mode_i        (mode_cfg_w),
    .mem_ok_i      (mem_ok_w),
    .mem_ready_i   (mem_ready),
    .mem_rdata_i   (mem_rdata),
    .dev_rx_valid_i(dev_rx_valid),
    .dev_rx_data_i (dev_rx_data),
    .dev_tx_ready_i(dev_tx_ready),
    .busy_o        (busy),
    .mem_phase_o   (mem_phase_w),
    .done_o        (done_w),
    .mode_run_o    (run_mode),
    .mem_valid_o   (mem_valid),
    .mem_we_o      (mem_we),
    .mem_addr_o    (mem_addr),
    .mem_wdata_o   (mem_wdata),
    .dev_sel_o     (dev_sel),
    .dev_rx_ready_o(dev_rx_ready),
    .dev_tx_valid_o(dev_tx_valid),
    .dev_tx_data_o (dev_tx_data)
  );

  bmv_share u_share (
    .mode_i      (run_mode),
    .busy_i      (busy),
    .mem_phase_i (mem_phase_w),
    .bus_grant_i (bus_grant),
    .slot_phase_i(slot_phase),
    .bus_req_o   (bus_req),
    .cpu_stop_o  (cpu_stop),
    .mem_ok_o    (mem_ok_w)
  );

endmodule

// File: rtl/bmv_checker.sv
module bmv_checker #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [2:0]    cfg_sel,
  input logic [AW-1:0] cfg_wdata,
  input logic          irq,
  input logic          busy,
  input logic          bus_req,
  input logic          bus_grant,
  input logic          cpu_stop,
  input logic          slot_phase,
  input logic          mem_valid,
  input logic          dev_rx_ready,
  input logic          dev_tx_valid,
  input logic [1:0]    run_mode
);

  logic clr_wr;
  assign clr_wr = cfg_we && (cfg_sel == 3'd4) && cfg_wdata[1];

  AST_HALT_HOLDS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && run_mode == 2'd0) |-> (bus_req && cpu_stop)); // R7

  AST_STOP_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_stop |-> busy); // R7

  AST_MEM_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && run_mode != 2'd2) |-> bus_grant); // R8

  AST_SLOT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && run_mode == 2'd2) |-> (slot_phase && !bus_req)); // R9

  AST_STEAL_DEV_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && run_mode == 2'd1) |-> (!dev_rx_ready && !dev_tx_valid)); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_valid && !dev_rx_ready && !dev_tx_valid && !bus_req)); // R4

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_wr) |=> irq); // R4

endmodule

bind bmv_top bmv_checker #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_we      (cfg_we),
  .cfg_sel     (cfg_sel),
  .cfg_wdata   (cfg_wdata),
  .irq         (irq),
  .busy        (busy),
  .bus_req     (bus_req),
  .bus_grant   (bus_grant),
  .cpu_stop    (cpu_stop),
  .slot_phase  (slot_phase),
  .mem_valid   (mem_valid),
  .dev_rx_ready(dev_rx_ready),
  .dev_tx_valid(dev_tx_valid),
  .run_mode    (run_mode)
);

// File: tb/tb_bmv_top.sv
module tb_bmv_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int DEVW = 4;

  typedef struct packed {
    logic [1:0] mode;
    logic       dir;
    logic [5:0] base;
    logic [5:0] cnt;
    logic [3:0] dev;
    logic       stall;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 6'd4,  6'd5, 4'd3,  1'b1},
    '{2'd1, 1'b0, 6'd12, 6'd4, 4'd5,  1'b1},
    '{2'd2, 1'b0, 6'd20, 6'd3, 4'd9,  1'b0},
    '{2'd0, 1'b1, 6'd30, 6'd4, 4'd2,  1'b1},
    '{2'd1, 1'b1, 6'd40, 6'd3, 4'd7,  1'b1},
    '{2'd2, 1'b1, 6'd48, 6'd6, 4'd12, 1'b0},
    '{2'd3, 1'b0, 6'd56, 6'd2, 4'd1,  1'b1}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_we;
  logic [2:0] cfg_sel;
  logic [AW-1:0] cfg_wdata;
  logic irq, busy, bus_req, cpu_stop, mem_valid, mem_we;
  logic bus_grant, slot_phase, mem_ready;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata, dev_rx_data, dev_tx_data;
  logic [DEVW-1:0] dev_sel;
  logic dev_rx_valid, dev_rx_ready, dev_tx_valid, dev_tx_ready;

  always #(CLK_PERIOD/2) clk = ~clk;

  bmv_top #(.AW(AW), .DW(DW), .DEVW(DEVW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .irq(irq), .busy(busy), .bus_req(bus_req), .bus_grant(bus_grant), .cpu_stop(cpu_stop),
    .slot_phase(slot_phase), .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready), .dev_sel(dev_sel),
    .dev_rx_valid(dev_rx_valid), .dev_rx_data(dev_rx_data), .dev_rx_ready(dev_rx_ready),
    .dev_tx_valid(dev_tx_valid), .dev_tx_data(dev_tx_data), .dev_tx_ready(dev_tx_ready)
  );

  logic [DW-1:0] mem [64];
  logic [DW-1:0] tx_log [64];
  assign mem_rdata = mem[mem_addr[5:0]];

  int checks = 0, fails = 0;
  int cyc = 0, rx_idx = 0, tx_n = 0, beats = 0, viol = 0, steal_gaps = 0;
  int mode_cur = 0;
  bit rx_stall = 0, grant_hold = 0, req_seen = 0, finished = 0;
  bit p_mem = 0, p_mw = 0, p_rx = 0, p_tx = 0;
  logic [5:0] p_addr;
  logic [DW-1:0] p_data, p_txd;

  function automatic logic [DW-1:0] dev_word(input logic [3:0] d, input int i);
    return {d, 4'hA, 8'(i)};
  endfunction

  function automatic logic [DW-1:0] seed_word(input int a);
    return 16'h3C00 + 16'(a);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory, device, grant and slot models; inputs change at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (p_mw) mem[p_addr] = p_data;
    if (p_rx) rx_idx++;
    if (p_tx) begin tx_log[tx_n[5:0]] = p_txd; tx_n++; end
    if (p_mem) beats++;
    bus_grant    = grant_hold ? 1'b0 : req_seen;
    req_seen     = bus_req;
    slot_phase   = ~slot_phase;
    mem_ready    = (cyc % 4) != 3;
    dev_rx_valid = rx_stall ? ((cyc % 3) != 1) : 1'b1;
    dev_rx_data  = dev_word(dev_sel, rx_idx);
    dev_tx_ready = (cyc % 5) != 0;
    #1;
    p_mem  = mem_valid && mem_ready;
    p_mw   = p_mem && mem_we;
    p_addr = mem_addr[5:0];
    p_data = mem_wdata;
    p_rx   = dev_rx_valid && dev_rx_ready;
    p_tx   = dev_tx_valid && dev_tx_ready;
    p_txd  = dev_tx_data;
    if (p_mem && ((mode_cur == 2) ? !(slot_phase && !bus_req) : !bus_grant)) viol++;
    if (busy && mode_cur == 0 && !(bus_req && cpu_stop)) viol++;
    if (mode_cur != 0 && cpu_stop) viol++;
    if (mode_cur == 2 && bus_req) viol++;
    if (mode_cur == 1 && bus_req && (dev_rx_ready || dev_tx_valid)) viol++;
    if (busy && mode_cur == 1 && !bus_req) steal_gaps++;
  end

  task automatic cfg_write(input logic [2:0] sel, input logic [AW-1:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic setup(input logic [1:0] mode, input logic dir, input int base,
                       input int cnt, input logic [3:0] dev);
    cfg_write(3'd0, AW'(base));
    cfg_write(3'd1, AW'(cnt));
    cfg_write(3'd2, AW'(dev));
    cfg_write(3'd3, {13'd0, mode, dir});
    cfg_write(3'd4, 16'h0002);
  endtask

  task automatic clear_counts();
    for (int a = 0; a < 64; a++) mem[a] = seed_word(a);
    rx_idx = 0; tx_n = 0; beats = 0; viol = 0; steal_gaps = 0;
  endtask

  task automatic wait_irq(input string req);
    int n = 0;
    while (!irq && n < 3000) begin @(negedge clk); n++; end
    chk(irq == 1'b1, req, irq, 1);
    @(negedge clk); #2;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    bus_grant = 1'b0; slot_phase = 1'b0; mem_ready = 1'b0;
    dev_rx_valid = 1'b0; dev_rx_data = '0; dev_tx_ready = 1'b0;
    clear_counts();
    repeat (3) @(negedge clk);
    chk({irq, busy, bus_req, cpu_stop, mem_valid} == 5'b0, "R1 in reset", {irq, busy, bus_req, cpu_stop, mem_valid}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #2;
    chk({irq, busy, bus_req, cpu_stop, mem_valid, dev_rx_ready, dev_tx_valid} == 7'b0,
        "R1 after release", {irq, busy, bus_req, cpu_stop, mem_valid, dev_rx_ready, dev_tx_valid}, 0);

    // table of transfers covering every mode and both directions
    for (int v = 0; v < NV; v++) begin
      vec_t t = VECS[v];
      int b = int'(t.base);
      int c = int'(t.cnt);
      mode_cur = (t.mode == 2'd3) ? 0 : int'(t.mode);
      rx_stall = t.stall;
      clear_counts();
      setup(t.mode, t.dir, b, c, t.dev);
      cfg_write(3'd4, 16'h0001);
      wait_irq("R4 irq at end");
      chk(!busy, "R4 busy falls", busy, 0);
      chk(beats == c, "R4 beat count", beats, c);
      chk(dev_sel == t.dev, "R3 device select", dev_sel, t.dev);
      if (mode_cur == 0)      chk(viol == 0, "R7 halt bus use", viol, 0);
      else if (mode_cur == 1) chk(viol == 0, "R8 steal bus use", viol, 0);
      else                    chk(viol == 0, "R9 slot bus use", viol, 0);
      if (mode_cur == 1) chk(steal_gaps > 0, "R8 bus released between words", steal_gaps, 1);
      if (!t.dir) begin
        for (int i = 0; i < c; i++)
          chk(mem[b+i] == dev_word(t.dev, i), "R2 stored word", mem[b+i], dev_word(t.dev, i));
        chk(mem[b-1] == seed_word(b-1), "R2 below region", mem[b-1], seed_word(b-1));
        chk(mem[b+c] == seed_word(b+c), "R2 above region", mem[b+c], seed_word(b+c));
      end else begin
        chk(tx_n == c, "R3 words delivered", tx_n, c);
        for (int i = 0; i < c; i++)
          chk(tx_log[i] == seed_word(b+i), "R3 delivered order", tx_log[i], seed_word(b+i));
      end
      repeat (6) @(negedge clk);
      chk(irq == 1'b1, "R4 irq held", irq, 1);
      cfg_write(3'd4, 16'h0002);
      #2;
      chk(irq == 1'b0, "R4 irq cleared", irq, 0);
    end

    // zero count: immediate completion, no memory traffic (R5)
    clear_counts();
    mode_cur = 0;
    setup(2'd0, 1'b0, 8, 0, 4'd1);
    cfg_write(3'd4, 16'h0001);
    #2;
    chk(irq == 1'b1, "R5 irq on zero count", irq, 1);
    chk(busy == 1'b0, "R5 stays idle", busy, 0);
    repeat (5) @(negedge clk);
    #2;
    chk(beats == 0, "R5 no memory access", beats, 0);
    cfg_write(3'd4, 16'h0002);

    // grant withheld in halt mode, restart and reprogram while stalled (R6, R7)
    clear_counts();
    mode_cur = 0;
    rx_stall = 0;
    grant_hold = 1;
    setup(2'd0, 1'b0, 2, 3, 4'd6);
    cfg_write(3'd4, 16'h0001);
    repeat (20) @(negedge clk);
    #2;
    chk(busy == 1'b1, "R7 stalled transfer busy", busy, 1);
    chk(mem_valid == 1'b0, "R7 no request without grant", mem_valid, 0);
    chk(beats == 0, "R7 no beats without grant", beats, 0);
    cfg_write(3'd1, 16'd9);
    cfg_write(3'd4, 16'h0001);
    chk(irq == 1'b0, "R6 restart ignored", irq, 0);
    grant_hold = 0;
    wait_irq("R6 completes");
    chk(beats == 3, "R6 original count kept", beats, 3);
    chk(mem[2] == dev_word(4'd6, 0) && mem[4] == dev_word(4'd6, 2), "R10 latched base", mem[4], dev_word(4'd6, 2));
    chk(mem[5] == seed_word(5), "R6 no extra word", mem[5], seed_word(5));
    cfg_write(3'd4, 16'h0002);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule